// File: doc/BRIEF.md
# Ping-Pong Capture Buffer Manager

This block decides where a stream of captured audio data lands in memory. Software provides two memory regions, A and B, each given by its own base address, and one length that both regions share. The block keeps a write offset inside the region in use. Each time the memory side accepts one 64-byte burst, the block moves the write address forward. When a region fills, the block marks it full and moves on to the other region, so that software can empty one region while the block fills the other.

Software hands a region back to the block by writing a fresh base address and pulsing that region's acknowledge. If a region fills while the other one has not been handed back, the block raises a sticky overrun flag. It then stops moving the address, so later bursts are dropped, until either region is handed back. The full flags and the overrun flag go to one level-sensitive interrupt output, and each of the three conditions has its own enable bit.

Top module: `pingpong_capture_mgr`

## Requirements
- R1: After reset the write address equals base A, which resets to 0. Region A is active, region B is selected by active_buf_o = 1, and the full flags, the overrun flag, stall_o and irq_o are all 0. Both regions start as available and every interrupt enable bit starts at 1.
- R2: Register writes go through reg_sel_i: 0 selects base A, 1 selects base B, 2 selects the size, and 3 selects the interrupt enables (bit 0 full A, bit 1 full B, bit 2 overrun). The low 6 bits of both bases and of the size are forced to zero, so written values in those bits have no effect.
- R3: Each burst_i pulse taken while capture is enabled and not stalled moves wr_addr_o forward by 64, provided the region does not fill.
- R4: A region fills on the burst that makes offset + 64 reach or pass the size. On the next clock its full flag is 1, it stops being available, and wr_addr_o shows the other region's base with offset 0.
- R5: An ack_a_i or ack_b_i pulse clears that region's full flag and makes the region available again, both visible on the next clock. A per-region acknowledge leaves the overrun flag unchanged.
- R6: If a region fills while the other region is not available, ovr_o and stall_o go to 1. Later bursts leave wr_addr_o and the flags unchanged.
- R7: Once set, ovr_o stays at 1 through any per-region acknowledge and through a resume. Only ack_ovr_i clears it, on the next clock.
- R8: While the block is stalled, an acknowledge for either region restarts capture in that region at offset 0 on the same clock edge.
- R9: irq_o is 1 exactly when some flag is set and its enable bit is 1. A masked flag still sets, but it does not assert irq_o.
- R10: While cap_en_i is 0, burst_i has no effect: the address, the active region and all flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_en_i | input | 1 | Capture enable; gates every address change |
| burst_i | input | 1 | One 64-byte burst accepted by memory |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 base A, 1 base B, 2 size, 3 irq enables) |
| reg_wdata_i | input | ADDR_W | Register write data |
| ack_a_i | input | 1 | Hand back region A / clear its full flag |
| ack_b_i | input | 1 | Hand back region B / clear its full flag |
| ack_ovr_i | input | 1 | Clear the overrun flag |
| wr_addr_o | output | ADDR_W | Byte address for the next burst |
| active_buf_o | output | 1 | Region in use (0 = A, 1 = B) |
| stall_o | output | 1 | Capture halted; no region available |
| full_a_o | output | 1 | Region A full flag |
| full_b_o | output | 1 | Region B full flag |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check five rules on every cycle: the write address stays aligned, the overrun flag stays set until its own acknowledge, an acknowledge clears its flag on the next clock, a full flag rises only after an enabled burst, and a stalled block holds its address when no acknowledge or write arrives. The bench scenarios are the only place the exact address sequence is shown, including the switch between regions at the size boundary, the overrun raised when software is late, the resume into whichever region is handed back first, and the effect of the interrupt enables.

// File: rtl/ppcap_pkg.sv
package ppcap_pkg;
  typedef enum logic [1:0] {
    SEL_BASE_A = 2'd0,
    SEL_BASE_B = 2'd1,
    SEL_SIZE   = 2'd2,
    SEL_IRQEN  = 2'd3
  } reg_sel_e;

  localparam int unsigned NBUF    = 2;
  localparam int unsigned NCOND   = 3;
  localparam int unsigned C_FULLA = 0;
  localparam int unsigned C_FULLB = 1;
  localparam int unsigned C_OVR   = 2;
endpackage

// File: rtl/ppcap_regs.sv
module ppcap_regs
  import ppcap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ALIGN_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] base_o [NBUF],
  output logic [ADDR_W-1:0] size_o,
  output logic [NCOND-1:0]  irq_en_o
);
  localparam int unsigned HI_W = ADDR_W - ALIGN_W;

  logic [HI_W-1:0] base_q [NBUF];
  logic [HI_W-1:0] size_q;
  logic [NCOND-1:0] en_q;

  for (genvar b = 0; b < NBUF; b++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) base_q[b] <= '0;
      else if (we_i && sel_i == 2'(b)) base_q[b] <= wdata_i[ADDR_W-1:ALIGN_W];
    end
    assign base_o[b] = {base_q[b], {ALIGN_W{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= '0;
      en_q   <= '1;
    end else if (we_i) begin
      if (sel_i == SEL_SIZE)  size_q <= wdata_i[ADDR_W-1:ALIGN_W];
      if (sel_i == SEL_IRQEN) en_q   <= wdata_i[NCOND-1:0];
    end
  end

  assign size_o   = {size_q, {ALIGN_W{1'b0}}};
  assign irq_en_o = en_q;
endmodule

// File: rtl/ppcap_ptr.sv
module ppcap_ptr
  import ppcap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ALIGN_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic              burst_i,
  input  logic [NBUF-1:0]   ack_i,
  input  logic [ADDR_W-1:0] base_i [NBUF],
  input  logic [ADDR_W-1:0] size_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              cur_o,
  output logic              stall_o,
  output logic [NBUF-1:0]   fill_o,
  output logic              ovr_set_o
);
  localparam logic [ADDR_W:0] STEP = (ADDR_W+1)'(1) << ALIGN_W;

  logic              cur_q, cur_d;
  logic [ADDR_W-1:0] off_q, off_d;
  logic [NBUF-1:0]   avail_q, avail_d, avail_ack, consume;
  logic [ADDR_W:0]   off_next;
  logic              halted, fills;

  assign avail_ack = avail_q | ack_i;
  assign halted    = !avail_q[cur_q];
  assign off_next  = {1'b0, off_q} + STEP;
  assign fills     = off_next >= {1'b0, size_i};

  always_comb begin
    cur_d     = cur_q;
    off_d     = off_q;
    consume   = '0;
    fill_o    = '0;
    ovr_set_o = 1'b0;
    if (cap_en_i) begin
      if (halted) begin
        // resume in whichever region was handed back; current one first
        if (!avail_ack[cur_q] && avail_ack[!cur_q]) cur_d = !cur_q;
        off_d = '0;
      end else if (burst_i) begin
        if (fills) begin
          consume[cur_q] = 1'b1;
          fill_o[cur_q]  = 1'b1;
          ovr_set_o      = !avail_ack[!cur_q];
          cur_d          = !cur_q;
          off_d          = '0;
        end else begin
          off_d = off_next[ADDR_W-1:0];
        end
      end
    end
    // an acknowledge in the same cycle wins over consumption
    avail_d = (avail_q & ~consume) | ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= 1'b0;
      off_q   <= '0;
      avail_q <= '1;
    end else begin
      cur_q   <= cur_d;
      off_q   <= off_d;
      avail_q <= avail_d;
    end
  end

  assign wr_addr_o = base_i[cur_q] + off_q;
  assign cur_o     = cur_q;
  assign stall_o   = halted;
endmodule

// File: rtl/ppcap_flags.sv
module ppcap_flags
  import ppcap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NBUF-1:0]  fill_i,
  input  logic [NBUF-1:0]  ack_i,
  input  logic             ovr_set_i,
  input  logic             ack_ovr_i,
  input  logic [NCOND-1:0] irq_en_i,
  output logic [NBUF-1:0]  full_o,
  output logic             ovr_o,
  output logic             irq_o
);
  logic [NBUF-1:0] full_q;
  logic            ovr_q;

  for (genvar b = 0; b < NBUF; b++) begin : g_full
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       full_q[b] <= 1'b0;
      else if (ack_i[b]) full_q[b] <= 1'b0;
      else if (fill_i[b]) full_q[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (ack_ovr_i) ovr_q <= 1'b0;
    else if (ovr_set_i) ovr_q <= 1'b1;
  end

  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign irq_o  = |({ovr_q, full_q[C_FULLB], full_q[C_FULLA]} & irq_en_i);
endmodule

// File: rtl/pingpong_capture_mgr.sv
module pingpong_capture_mgr
  import ppcap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ALIGN_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic              burst_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              ack_a_i,
  input  logic              ack_b_i,
  input  logic              ack_ovr_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              active_buf_o,
  output logic              stall_o,
  output logic              full_a_o,
  output logic              full_b_o,
  output logic              ovr_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] base [NBUF];
  logic [ADDR_W-1:0] size;
  logic [NCOND-1:0]  irq_en;
  logic [NBUF-1:0]   acks, fill, full;
  logic              ovr_set;

  assign acks = {ack_b_i, ack_a_i};

  ppcap_regs #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i     (reg_we_i),
    .sel_i    (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .base_o   (base),
    .size_o   (size),
    .irq_en_o (irq_en)
  );

  ppcap_ptr #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_ptr (
    .clk_i, .rst_ni,
    .cap_en_i,
    .burst_i,
    .ack_i     (acks),
    .base_i    (base),
    .size_i    (size),
    .wr_addr_o (wr_addr_o),
    .cur_o     (active_buf_o),
    .stall_o   (stall_o),
    .fill_o    (fill),
    .ovr_set_o (ovr_set)
  );

  ppcap_flags u_flags (
    .clk_i, .rst_ni,
    .fill_i    (fill),
    .ack_i     (acks),
    .ovr_set_i (ovr_set),
    .ack_ovr_i (ack_ovr_i),
    .irq_en_i  (irq_en),
    .full_o    (full),
    .ovr_o     (ovr_o),
    .irq_o     (irq_o)
  );

  assign full_a_o = full[C_FULLA];
  assign full_b_o = full[C_FULLB];
endmodule

// File: rtl/ppcap_chk.sv
module ppcap_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ALIGN_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cap_en_i,
  input logic              burst_i,
  input logic              reg_we_i,
  input logic              ack_a_i,
  input logic              ack_b_i,
  input logic              ack_ovr_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              stall_o,
  input logic              full_a_o,
  input logic              full_b_o,
  input logic              ovr_o
);
  p_addr_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr_o[ALIGN_W-1:0] == '0);

  p_ovr_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o && !ack_ovr_i |=> ovr_o);

  p_ovr_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ovr_i |=> !ovr_o);

  p_ack_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_a_i |=> !full_a_o);

  p_ack_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_b_i |=> !full_b_o);

  p_full_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_a_o) || $rose(full_b_o) |-> $past(cap_en_i && burst_i));

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && !ack_a_i && !ack_b_i && !reg_we_i |=> $stable(wr_addr_o) && stall_o);
endmodule

bind pingpong_capture_mgr ppcap_chk #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_chk (
  .clk_i, .rst_ni, .cap_en_i, .burst_i, .reg_we_i,
  .ack_a_i, .ack_b_i, .ack_ovr_i,
  .wr_addr_o, .stall_o, .full_a_o, .full_b_o, .ovr_o
);

// File: tb/pingpong_capture_mgr_tb.sv
module pingpong_capture_mgr_tb;
  localparam int unsigned AW = 32;

  typedef struct packed {
    logic          burst, aa, ab, ao;
    logic [AW-1:0] addr;
    logic          fa, fb, ov, st, irq;
  } vec_t;

  // base A 0x1000, base B 0x2000, size 0x80 (two bursts), all enables on
  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0, 32'h1040, 1'b0,1'b0,1'b0,1'b0,1'b0}, // R3
    '{1'b1,1'b0,1'b0,1'b0, 32'h2000, 1'b1,1'b0,1'b0,1'b0,1'b1}, // R4
    '{1'b0,1'b1,1'b0,1'b0, 32'h2000, 1'b0,1'b0,1'b0,1'b0,1'b0}, // R5
    '{1'b1,1'b0,1'b0,1'b0, 32'h2040, 1'b0,1'b0,1'b0,1'b0,1'b0}, // R3
    '{1'b1,1'b0,1'b0,1'b0, 32'h1000, 1'b0,1'b1,1'b0,1'b0,1'b1}, // R4
    '{1'b1,1'b0,1'b0,1'b0, 32'h1040, 1'b0,1'b1,1'b0,1'b0,1'b1}, // R3
    '{1'b1,1'b0,1'b0,1'b0, 32'h2000, 1'b1,1'b1,1'b1,1'b1,1'b1}, // R6
    '{1'b1,1'b0,1'b0,1'b0, 32'h2000, 1'b1,1'b1,1'b1,1'b1,1'b1}, // R6
    '{1'b0,1'b1,1'b0,1'b0, 32'h1000, 1'b0,1'b1,1'b1,1'b0,1'b1}, // R8
    '{1'b0,1'b0,1'b1,1'b0, 32'h1000, 1'b0,1'b0,1'b1,1'b0,1'b1}, // R7
    '{1'b0,1'b0,1'b0,1'b1, 32'h1000, 1'b0,1'b0,1'b0,1'b0,1'b0}, // R7
    '{1'b1,1'b0,1'b0,1'b0, 32'h1040, 1'b0,1'b0,1'b0,1'b0,1'b0}  // R3
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cap_en_i = 1'b0, burst_i = 1'b0, reg_we_i = 1'b0;
  logic [1:0] reg_sel_i = '0;
  logic [AW-1:0] reg_wdata_i = '0;
  logic ack_a_i = 1'b0, ack_b_i = 1'b0, ack_ovr_i = 1'b0;
  logic [AW-1:0] wr_addr_o;
  logic active_buf_o, stall_o, full_a_o, full_b_o, ovr_o, irq_o;

  int checks = 0, errors = 0;

  always #5 clk_i = !clk_i;

  pingpong_capture_mgr #(.ADDR_W(AW), .ALIGN_W(6)) u_dut (.*);

  task automatic chk(input logic ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic aa, input logic ab, input logic ao);
    @(negedge clk_i);
    burst_i = b; ack_a_i = aa; ack_b_i = ab; ack_ovr_i = ao;
    @(posedge clk_i); #1;
    burst_i = 1'b0; ack_a_i = 1'b0; ack_b_i = 1'b0; ack_ovr_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic chk_state(input string req, input logic [AW-1:0] a,
                           input logic fa, input logic fb, input logic ov,
                           input logic st, input logic irq);
    chk(wr_addr_o == a, {req, " addr"}, wr_addr_o, a);
    chk({full_a_o, full_b_o, ovr_o, stall_o, irq_o} == {fa, fb, ov, st, irq},
        {req, " flags fa/fb/ov/st/irq"},
        AW'({full_a_o, full_b_o, ovr_o, stall_o, irq_o}), AW'({fa, fb, ov, st, irq}));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk_state("R1", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(active_buf_o == 1'b0, "R1 active", AW'(active_buf_o), 0);
    rst_ni = 1'b1;

    // R2 low bits of writes ignored
    wr(2'd0, 32'h0000_103F);
    chk(wr_addr_o == 32'h1000, "R2 base A", wr_addr_o, 32'h1000);
    wr(2'd1, 32'h0000_2011);
    wr(2'd2, 32'h0000_00BF);
    cap_en_i = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].burst, TBL[i].aa, TBL[i].ab, TBL[i].ao);
      chk_state($sformatf("vec%0d R3/R4/R5/R6/R7/R8", i), TBL[i].addr,
                TBL[i].fa, TBL[i].fb, TBL[i].ov, TBL[i].st, TBL[i].irq);
    end
    chk(active_buf_o == 1'b0, "R8 active A", AW'(active_buf_o), 0);

    // R10 burst ignored while disabled
    cap_en_i = 1'b0;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk_state("R10", 32'h1040, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    cap_en_i = 1'b1;

    // R9 only full B enabled (bit 1)
    wr(2'd3, 32'h2);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk_state("R9 masked full A", 32'h2000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk_state("R9 full B R6", 32'h1000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    // R8 resume into B when only B is handed back; R9 masked overrun no irq
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk_state("R8 resume B R9", 32'h2000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(active_buf_o == 1'b1, "R8 active B", AW'(active_buf_o), 1);
    // R2 base write low bits ignored, seen on active region B
    wr(2'd1, 32'h0000_3023);
    chk(wr_addr_o == 32'h3000, "R2 base B", wr_addr_o, 32'h3000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule